// File: doc/BRIEF.md
# Masked Associative Tag Store

This block is a synchronous associative memory that holds a set of tag words, each marked present or absent by its own validity flag. Software or a controller fills it through ordinary addressed writes. It can read any word back by address, and it can drop a word by clearing the flag. The main operation is a search. The search compares one stored comparand against every present word at once. Bit positions that are set in a separate mask register are left out of the comparison.

All present words that agree with the comparand are reduced to one result: the smallest matching index, together with a hit flag. Both are registered and appear on the clock after the search command. Operations arrive on a single command port that uses valid/ready signalling. The block never applies back-pressure: `cmd_ready` is held high outside reset, so every command presented with `cmd_valid` is taken on that edge. Results carry no back-pressure either. `rsp_valid` pulses for one cycle, and the read and search result registers hold their values until the next command of the same kind overwrites them.

Top module: `cam_masked`

## Requirements
- R1: After reset every validity flag is clear, the comparand and mask registers are zero, and `hit`, `match_addr`, `rsp_valid`, `rd_word_valid` and `rd_data` are all zero.
- R2: A write command (op 2) stores `cmd_data` at `cmd_addr` and sets that word's validity flag.
- R3: An invalidate command (op 4) clears the validity flag of the word at `cmd_addr`, so a later read reports it absent and no search matches it.
- R4: A search (op 3) treats a word as matching only when its flag is set and every unmasked bit equals the comparand; one differing unmasked bit prevents the match.
- R5: A mask bit of 1 removes that bit position from the comparison, so an all-ones mask matches every present word.
- R6: When several words match, `match_addr` reports the lowest matching index.
- R7: When no word matches, `hit` is 0 and `match_addr` is 0.
- R8: The search result appears on the clock edge after the search command, with `rsp_valid` high for that one cycle, and it holds until the next search.
- R9: Load-comparand (op 5) and load-mask (op 6) capture `cmd_data`, and a search issued on the following cycle uses the new values.
- R10: Opcodes are 0 idle, 1 read, 2 write, 3 search, 4 invalidate, 5 load comparand and 6 load mask. Op 7 and any cycle with `cmd_valid` low change nothing. `cmd_ready` is high whenever reset is released.
- R11: A read (op 1) returns the word's data and validity flag on the next edge with `rsp_valid` high, and holds them until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted (high outside reset) |
| cmd_op | input | 3 | Operation code |
| cmd_addr | input | 9 | Word index for read, write and invalidate |
| cmd_data | input | 64 | Write data, comparand or mask value |
| rsp_valid | output | 1 | One-cycle pulse after a read or a search |
| rd_data | output | 64 | Data of the last word read |
| rd_word_valid | output | 1 | Validity flag of the last word read |
| hit | output | 1 | Last search found at least one match |
| match_addr | output | 9 | Lowest matching index of the last search |

## Verification
A corrupted validity flag, stored word or mask bit stays hidden until a search or read reaches it. The bench's reference model therefore compares every output on every clock, and it issues searches straight after each write and invalidate, so that a wrong internal state shows up one cycle after the next probe. Stale or wrongly ordered match vectors show up as a wrong `match_addr` whenever two or more present words share the searched bits. For this reason the bench deliberately writes duplicates at high and low indices.

// File: rtl/cam_pkg.sv
package cam_pkg;
  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_READ  = 3'd1,
    OP_WRITE = 3'd2,
    OP_FIND  = 3'd3,
    OP_DROP  = 3'd4,
    OP_LDCMP = 3'd5,
    OP_LDMSK = 3'd6
  } cam_op_e;
endpackage

// File: rtl/cam_store.sv
module cam_store #(
  parameter int WORDS = 512,
  parameter int WIDTH = 64,
  localparam int AW = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             drop_en,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] words [WORDS],
  output logic [WORDS-1:0] present
);
  // storage: data has no reset, only the flags do
  always_ff @(posedge clk) begin
    if (wr_en) words[addr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) present <= '0;
    else if (wr_en) present[addr] <= 1'b1;
    else if (drop_en) present[addr] <= 1'b0;
  end
endmodule

// File: rtl/cam_match.sv
module cam_match #(
  parameter int WORDS = 512,
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0] words [WORDS],
  input  logic [WORDS-1:0] present,
  input  logic [WIDTH-1:0] key,
  input  logic [WIDTH-1:0] ignore,
  output logic [WORDS-1:0] agree
);
  // one comparator per word; any unmasked differing bit kills the line
  for (genvar g = 0; g < WORDS; g++) begin : g_line
    logic [WIDTH-1:0] diff;
    assign diff     = (words[g] ^ key) & ~ignore;
    assign agree[g] = present[g] & ~(|diff);
  end
endmodule

// File: rtl/cam_prio.sv
module cam_prio #(
  parameter int WORDS = 512,
  localparam int AW = $clog2(WORDS)
) (
  input  logic [WORDS-1:0] req,
  output logic             any,
  output logic [AW-1:0]    idx
);
  // scan from the top so the lowest set index is the last one written
  always_comb begin
    idx = '0;
    for (int i = WORDS - 1; i >= 0; i--) begin
      if (req[i]) idx = AW'(i);
    end
  end
  assign any = |req;
endmodule

// File: rtl/cam_masked.sv
module cam_masked
  import cam_pkg::*;
#(
  parameter int WORDS = 512,
  parameter int WIDTH = 64,
  localparam int AW = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_op,
  input  logic [AW-1:0]    cmd_addr,
  input  logic [WIDTH-1:0] cmd_data,
  output logic             rsp_valid,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_word_valid,
  output logic             hit,
  output logic [AW-1:0]    match_addr
);
  logic             go_rd, go_wr, go_find, go_drop, go_ldc, go_ldm;
  logic [WIDTH-1:0] key_q, ign_q;
  logic [WIDTH-1:0] words [WORDS];
  logic [WORDS-1:0] present;
  logic [WORDS-1:0] agree;
  logic             any_c;
  logic [AW-1:0]    idx_c;
  logic             rdy_q;

  assign go_rd   = cmd_valid && cmd_op == OP_READ;
  assign go_wr   = cmd_valid && cmd_op == OP_WRITE;
  assign go_find = cmd_valid && cmd_op == OP_FIND;
  assign go_drop = cmd_valid && cmd_op == OP_DROP;
  assign go_ldc  = cmd_valid && cmd_op == OP_LDCMP;
  assign go_ldm  = cmd_valid && cmd_op == OP_LDMSK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end
  assign cmd_ready = rdy_q;

  cam_store #(.WORDS(WORDS), .WIDTH(WIDTH)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(go_wr), .drop_en(go_drop),
    .addr(cmd_addr), .wdata(cmd_data), .words(words), .present(present)
  );

  cam_match #(.WORDS(WORDS), .WIDTH(WIDTH)) u_match (
    .words(words), .present(present), .key(key_q), .ignore(ign_q),
    .agree(agree)
  );

  cam_prio #(.WORDS(WORDS)) u_prio (
    .req(agree), .any(any_c), .idx(idx_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q         <= '0;
      ign_q         <= '0;
      rsp_valid     <= 1'b0;
      rd_data       <= '0;
      rd_word_valid <= 1'b0;
      hit           <= 1'b0;
      match_addr    <= '0;
    end else begin
      rsp_valid <= go_rd || go_find;
      if (go_ldc) key_q <= cmd_data;
      if (go_ldm) ign_q <= cmd_data;
      if (go_rd) begin
        rd_data       <= words[cmd_addr];
        rd_word_valid <= present[cmd_addr];
      end
      if (go_find) begin
        hit        <= any_c;
        match_addr <= any_c ? idx_c : '0;
      end
    end
  end
endmodule

// File: rtl/cam_masked_chk.sv
module cam_masked_chk #(
  parameter int AW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic [2:0]    cmd_op,
  input logic          rsp_valid,
  input logic          hit,
  input logic [AW-1:0] match_addr,
  input logic          rd_word_valid,
  input logic [63:0]   rd_data
);
  p_nohit_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> match_addr == '0);

  p_rsp_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_op == 3'd1 || cmd_op == 3'd3)) |=> rsp_valid);

  p_rsp_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && (cmd_op == 3'd1 || cmd_op == 3'd3)) |=> !rsp_valid);

  p_find_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_op == 3'd3) |=> $stable(hit) && $stable(match_addr));

  p_read_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_op == 3'd1) |=> $stable(rd_word_valid) && $stable(rd_data));
endmodule

bind cam_masked cam_masked_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .rsp_valid(rsp_valid), .hit(hit), .match_addr(match_addr),
  .rd_word_valid(rd_word_valid), .rd_data(rd_data)
);

// File: tb/sim_cam_masked.sv
`timescale 1ns/1ps
module sim_cam_masked;
  localparam int N  = 512;
  localparam int W  = 64;
  localparam int AW = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [2:0]    cmd_op = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [W-1:0]  cmd_data = '0;
  logic          rsp_valid;
  logic [W-1:0]  rd_data;
  logic          rd_word_valid;
  logic          hit;
  logic [AW-1:0] match_addr;

  always #4 clk = ~clk;

  cam_masked u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .rsp_valid(rsp_valid), .rd_data(rd_data), .rd_word_valid(rd_word_valid),
    .hit(hit), .match_addr(match_addr)
  );

  // behavioural reference state
  logic [W-1:0] m_data [N];
  bit           m_vld  [N];
  bit           m_wr   [N];
  logic [W-1:0] m_key = '0, m_ign = '0;
  bit           e_rsp = 0, e_rdv = 0, e_hit = 0, e_rdchk = 1;
  logic [W-1:0] e_rd = '0;
  int           e_addr = 0;
  int           checks = 0, fails = 0;
  bit           done = 0;

  function automatic bit agrees(int i);
    return m_vld[i] && (((m_data[i] ^ m_key) & ~m_ign) == '0);
  endfunction

  task automatic model_edge(bit v, int op, int a, logic [W-1:0] d);
    e_rsp = v && (op == 1 || op == 3);
    if (!v) return;
    case (op)
      1: begin e_rdv = m_vld[a]; e_rdchk = m_wr[a]; e_rd = m_data[a]; end
      2: begin m_data[a] = d; m_vld[a] = 1; m_wr[a] = 1; end
      3: begin
        e_hit = 0; e_addr = 0;
        for (int i = 0; i < N; i++) if (!e_hit && agrees(i)) begin e_hit = 1; e_addr = i; end
      end
      4: m_vld[a] = 0;
      5: m_key = d;
      6: m_ign = d;
      default: ;
    endcase
  endtask

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all(string req);
    chk(cmd_ready == 1'b1, "R10", "cmd_ready", cmd_ready, 1);
    chk(rsp_valid == e_rsp, req, "rsp_valid", rsp_valid, e_rsp);
    chk(hit == e_hit, req, "hit", hit, e_hit);
    chk(match_addr == AW'(e_addr), req, "match_addr", match_addr, e_addr);
    chk(rd_word_valid == e_rdv, req, "rd_word_valid", rd_word_valid, e_rdv);
    if (e_rdchk) chk(rd_data === e_rd, req, "rd_data", rd_data, e_rd);
  endtask

  // called at a negedge; returns at the following negedge after comparing
  task automatic cmd(bit v, int op, int a, logic [W-1:0] d, string req);
    cmd_valid = v; cmd_op = 3'(op); cmd_addr = AW'(a); cmd_data = d;
    @(posedge clk);
    model_edge(v, op, a, d);
    @(negedge clk);
    compare_all(req);
  endtask

  task automatic find(logic [W-1:0] key, logic [W-1:0] ign, string req);
    cmd(1, 5, 0, key, "R9");
    cmd(1, 6, 0, ign, "R9");
    cmd(1, 3, 0, '0, req);
    cmd(0, 0, 0, '0, req);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin m_vld[i] = 0; m_wr[i] = 0; m_data[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: state after reset
    chk(hit == 0 && match_addr == 0 && rsp_valid == 0 && rd_word_valid == 0 && rd_data == 0,
        "R1", "reset outputs", {hit, rsp_valid, rd_word_valid}, 0);
    find('0, '1, "R1");                 // all-ones mask, nothing present: R7
    cmd(1, 1, 5, '0, "R11");            // absent word reads flag 0
    // R2 write then read
    cmd(1, 2, 3,   64'hDEAD_BEEF_0000_1111, "R2");
    cmd(1, 2, 10,  64'h1234_5678_9ABC_DEF0, "R2");
    cmd(1, 2, 511, 64'h1234_5678_9ABC_DEF0, "R2");
    cmd(1, 1, 3, '0, "R2");
    cmd(1, 1, 511, '0, "R11");
    cmd(0, 0, 0, '0, "R11");
    // R6 duplicate at 10 and 511
    find(64'h1234_5678_9ABC_DEF0, '0, "R6");
    // R4 one differing bit
    find(64'h1234_5678_9ABC_DEF1, '0, "R4");
    // R5 masked differing bit
    find(64'h1234_5678_9ABC_DEF1, 64'h1, "R5");
    find('0, '1, "R5");
    // R3 invalidate 10, then search reports 511
    cmd(1, 4, 10, '0, "R3");
    find(64'h1234_5678_9ABC_DEF0, '0, "R3");
    cmd(1, 1, 10, '0, "R3");
    // R10 idle-valid-low and op 7 change nothing
    cmd(0, 2, 20, 64'h55, "R10");
    cmd(1, 7, 20, 64'h55, "R10");
    cmd(1, 1, 20, '0, "R10");
    find(64'h55, '0, "R10");
    // R8 back-to-back searches with a result hold in between
    cmd(1, 3, 0, '0, "R8");
    cmd(0, 0, 0, '0, "R8");
    cmd(0, 0, 0, '0, "R8");
    // R7 a miss
    find(64'hFFFF_0000_FFFF_0000, '0, "R7");
    // mixed traffic with duplicates and masks
    for (int k = 0; k < 300; k++) begin
      int a, op;
      logic [W-1:0] d;
      a  = $urandom_range(0, N - 1);
      op = $urandom_range(0, 7);
      d  = {$urandom(), $urandom()} & 64'h0000_00FF_0000_0F0F;
      if (op == 3 && k % 3 == 0) find(d, {$urandom(), $urandom()} & 64'h0000_00F0_0000_0F00, "R6");
      else cmd($urandom_range(0, 4) != 0, op, a, d, "R4");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule